// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block is the digital front end of a pair of 12-bit converter channels fed from an 8-bit parallel processor bus. A processor builds each channel's code from two bus writes. One write carries the eight low bits. The other carries the four high bits, right-justified in the bus byte. These writes land in a staging (input) register per channel and do not yet reach the converter.

A separate update strobe, given with a write pulse, copies both staged codes into the output registers on the same clock edge. Both converter words therefore change together.

An active-low clear zeroes every staged and output register at once, with no clock needed. Its release is synchronised to the system clock. The bus strobes are asynchronous to the system clock. They pass through a two-flop synchroniser, and a write takes effect on the rising edge of the synchronised write strobe.

Top module: `dual_dac_loader`

## Requirements
- R1: A synchronous active-high `rst` drives both output codes to zero, and all staged codes to zero.
- R2: A write with chip-select low and address 2'b00 loads `data` into channel A's low byte. Address 2'b10 loads channel B's low byte.
- R3: A write with chip-select low and address 2'b01 (channel A) or 2'b11 (channel B) loads `data[3:0]` into that channel's four high bits. `data[7:4]` has no effect.
- R4: While no write carries the update strobe, both output codes keep their values, whatever is written into the staged registers.
- R5: A write with update low copies both staged codes into both outputs in the same clock cycle. Chip-select need not be low for this.
- R6: When chip-select and update are both low in one write, the staged register is written first. The following transfer carries the newly written value.
- R7: A write pulse with chip-select and update both high changes nothing.
- R8: Taking `clr_n` low forces both output codes to zero at once, with no clock edge.
- R9: The clear also zeroes the staged codes, so an update after a clear outputs zero.
- R10: Writes made while `clr_n` is low are discarded. No register updates on the first clock edge after `clr_n` returns high.
- R11: A write commits only after the synchronised write strobe rises. Holding `wr_n` low with update low leaves the outputs unchanged until `wr_n` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of all code registers |
| wr_n | input | 1 | Active-low bus write strobe |
| cs_n | input | 1 | Active-low chip select for staged-register writes |
| upd_n | input | 1 | Active-low update strobe, acts with `wr_n` |
| addr | input | 2 | Slot select: bit 1 channel (0 = A, 1 = B), bit 0 part (0 = low byte, 1 = high nibble) |
| data | input | 8 | Bus data, right-justified |
| dac_a | output | 12 | Channel A converter code |
| dac_b | output | 12 | Channel B converter code |

## Verification
A staged-register write and the output transfer can be requested by one bus pulse, with chip-select and update both low. The bench provokes this twice, once on channel B's high nibble and once on its low byte. It judges the output against the freshly written byte, not the stale staged value. A clear that arrives while a write strobe is low is the second collision. Its write must vanish, and the outputs must read zero before any clock edge.

// File: rtl/dacld_pkg.sv
package dacld_pkg;

    localparam int BUS_W  = 8;
    localparam int LO_W   = 8;
    localparam int HI_W   = 4;
    localparam int CODE_W = LO_W + HI_W;
    localparam int NUM_CH = 2;
    localparam int STROBES = 3;

    typedef enum logic {
        PART_LO = 1'b0,
        PART_HI = 1'b1
    } part_e;

    // slot encoding is behavioural: bit 1 channel, bit 0 part
    typedef struct packed {
        logic  ch;
        part_e part;
    } slot_t;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } chan_code_t;

    typedef struct packed {
        slot_t            slot;
        logic [BUS_W-1:0] data;
        logic             cs;
        logic             upd;
    } bus_cmd_t;

    function automatic int slot_index(input slot_t s);
        return int'({s.ch, s.part});
    endfunction

endpackage

// File: rtl/dacld_sync.sv
module dacld_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '1;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/dacld_capture.sv
module dacld_capture
    import dacld_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_s,
    input  logic             cs_s,
    input  logic             upd_s,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] data,
    output logic             commit,
    output bus_cmd_t         cmd
);
    logic wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b1;
            cmd  <= '0;
        end else begin
            wr_q <= wr_s;
            if (!wr_s) begin
                cmd.slot <= slot_t'(addr);
                cmd.data <= data;
                cmd.cs   <= !cs_s;
                cmd.upd  <= !upd_s;
            end
        end
    end

    assign commit = wr_s && !wr_q;

    assert_single_commit_R11: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/dacld_regs.sv
module dacld_regs
    import dacld_pkg::*;
#(
    parameter int CLR_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              commit,
    input  bus_cmd_t          cmd,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b
);
    localparam int SLOTS = 2 * NUM_CH;

    logic [CLR_STAGES-1:0]     clr_pipe;
    logic                      clr_ok;
    logic [SLOTS-1:0]          slot_we;
    logic                      pend_q;
    logic                      do_xfer;
    chan_code_t [NUM_CH-1:0]   in_q;
    chan_code_t [NUM_CH-1:0]   out_q;

    // clear asserts asynchronously, releases through a short pipe
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) clr_pipe <= '0;
        else        clr_pipe <= {clr_pipe[CLR_STAGES-2:0], 1'b1};
    end
    assign clr_ok = clr_pipe[CLR_STAGES-1];

    always_comb begin
        slot_we = '0;
        if (commit && cmd.cs && clr_ok) slot_we[slot_index(cmd.slot)] = 1'b1;
    end

    assign do_xfer = pend_q && clr_ok;

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            in_q   <= '0;
            out_q  <= '0;
            pend_q <= 1'b0;
        end else if (rst) begin
            in_q   <= '0;
            out_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (slot_we[2*c])   in_q[c].lo <= cmd.data[LO_W-1:0];
                if (slot_we[2*c+1]) in_q[c].hi <= cmd.data[HI_W-1:0];
            end
            pend_q <= commit && cmd.upd && clr_ok;
            if (do_xfer) out_q <= in_q;
        end
    end

    assign dac_a = out_q[0];
    assign dac_b = out_q[1];

    assert_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (!rst && !do_xfer) |=> ($stable(dac_a) && $stable(dac_b)));

    assert_xfer_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (!rst && do_xfer) |=> (dac_a == $past(in_q[0]) && dac_b == $past(in_q[1])));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_a == '0 && dac_b == '0));

    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !clr_ok) |=> ($stable(in_q) && $stable(out_q)));

    assert_one_slot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_we));
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dacld_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CLR_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              wr_n,
    input  logic              cs_n,
    input  logic              upd_n,
    input  logic [1:0]        addr,
    input  logic [BUS_W-1:0]  data,
    output logic [CODE_W-1:0] dac_a,
    output logic [CODE_W-1:0] dac_b
);
    logic [STROBES-1:0] strobe_s;
    logic               commit;
    bus_cmd_t           cmd;

    dacld_sync #(.W(STROBES), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({wr_n, cs_n, upd_n}),
        .sync_out (strobe_s)
    );

    dacld_capture i_capture (
        .clk    (clk),
        .rst    (rst),
        .wr_s   (strobe_s[2]),
        .cs_s   (strobe_s[1]),
        .upd_s  (strobe_s[0]),
        .addr   (addr),
        .data   (data),
        .commit (commit),
        .cmd    (cmd)
    );

    dacld_regs #(.CLR_STAGES(CLR_STAGES)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .commit (commit),
        .cmd    (cmd),
        .dac_a  (dac_a),
        .dac_b  (dac_b)
    );
endmodule

// File: tb/test_dual_dac_loader.sv
module test_dual_dac_loader;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  data = '0;
    logic [11:0] dac_a;
    logic [11:0] dac_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dac_loader i_dual_dac_loader (
        .clk(clk), .rst(rst), .clr_n(clr_n), .wr_n(wr_n), .cs_n(cs_n),
        .upd_n(upd_n), .addr(addr), .data(data), .dac_a(dac_a), .dac_b(dac_b)
    );

    // {cs_n, upd_n, addr, data, expected A, expected B}
    localparam logic [35:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 2'b00, 8'h5A, 12'h000, 12'h000},  // R2 A low staged, R4 hold
        {1'b0, 1'b1, 2'b01, 8'hF3, 12'h000, 12'h000},  // R3 A high staged, R4 hold
        {1'b1, 1'b0, 2'b00, 8'h00, 12'h35A, 12'h000},  // R5 update only, R3 upper bits dropped
        {1'b0, 1'b1, 2'b10, 8'hC7, 12'h35A, 12'h000},  // R2 B low staged
        {1'b0, 1'b0, 2'b11, 8'h2E, 12'h35A, 12'hEC7},  // R6 write plus update
        {1'b0, 1'b1, 2'b00, 8'hFF, 12'h35A, 12'hEC7},  // R4 hold
        {1'b0, 1'b1, 2'b01, 8'h0A, 12'h35A, 12'hEC7},  // R4 hold
        {1'b1, 1'b1, 2'b00, 8'h11, 12'h35A, 12'hEC7},  // R7 ignored pulse
        {1'b1, 1'b0, 2'b01, 8'h99, 12'hAFF, 12'hEC7},  // R5 / R7 check low byte kept FF
        {1'b0, 1'b0, 2'b10, 8'h00, 12'hAFF, 12'hE00}   // R6 write plus update
    };

    task automatic check(input string req, input logic [11:0] a_exp, input logic [11:0] b_exp);
        n_run++;
        if (dac_a !== a_exp || dac_b !== b_exp) begin
            n_fail++;
            $display("FAIL %s: dac_a=%h dac_b=%h expected dac_a=%h dac_b=%h",
                     req, dac_a, dac_b, a_exp, b_exp);
        end
    endtask

    task automatic bus_write(input logic c, input logic u, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; data = d; cs_n = c; upd_n = u; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; upd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", 12'h000, 12'h000);

        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:24]);
            check($sformatf("R2-R7 vector %0d", i), VEC[i][23:12], VEC[i][11:0]);
        end

        // R11: strobe held low with update does nothing until released
        bus_write(1'b0, 1'b1, 2'b00, 8'h21);
        @(negedge clk);
        upd_n = 1'b0; cs_n = 1'b1; wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R11 held strobe", 12'hAFF, 12'hE00);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        upd_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R11 after release", 12'hA21, 12'hE00);

        // R8: asynchronous clear, sampled mid-cycle before any edge
        @(posedge clk);
        #1 clr_n = 1'b0;
        #1 check("R8 async clear", 12'h000, 12'h000);
        @(negedge clk);
        // R10: write during clear is discarded
        bus_write(1'b0, 1'b0, 2'b00, 8'h77);
        check("R10 write during clear", 12'h000, 12'h000);
        // R10: update pulse timed to commit right after release
        @(negedge clk);
        upd_n = 1'b0; cs_n = 1'b0; addr = 2'b10; data = 8'h44; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        clr_n = 1'b1;
        repeat (6) @(negedge clk);
        upd_n = 1'b1; cs_n = 1'b1;
        check("R10 commit at release edge", 12'h000, 12'h000);

        // R9: staged codes were wiped too
        bus_write(1'b1, 1'b0, 2'b00, 8'h00);
        check("R9 staged cleared", 12'h000, 12'h000);

        // R1: synchronous reset after loading
        bus_write(1'b0, 1'b0, 2'b01, 8'h06);
        check("R3 load before reset", 12'h600, 12'h000);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1 sync reset", 12'h000, 12'h000);
        bus_write(1'b1, 1'b0, 2'b00, 8'h00);
        check("R1 staged reset", 12'h000, 12'h000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule